// File: doc/BRIEF.md
# SPI Byte-Addressed Memory Slave

This block is the pin-side front end of a byte-addressed memory on a four-wire serial bus. The bus pins (select, clock, data in) are resynchronised into the system clock domain. Edge detectors find the serial clock transitions. The first byte shifted in after select goes low is decoded as a command. Read and write commands then take a three-byte address and move data in bursts against a byte array held inside the block. The block also holds an 8-bit status register with a write-enable latch.

The bus master may idle the serial clock either low or high. In both cases the block samples input bits on rising clock edges and updates its output bit on falling edges. The serial output has a separate enable, and it is driven only while a read-type command is in progress. If the command byte is not recognised, the block stops responding until select goes low again.

Top module: `spi_fram_slave`

## Requirements
- R1: Command, address and data bits are transferred most significant bit first. Both clock polarities work: clock idling low and clock idling high. Input bits are taken on rising clock edges only, and a rising edge counts only after it follows a low clock level while select is low.
- R2: The first byte after select falls is the command. The valid command codes are 0x06 (set write enable), 0x04 (clear write enable), 0x05 (read status), 0x01 (write status), 0x03 (read data) and 0x02 (write data).
- R3: Read and write carry a 24-bit address. Only the low 19 bits are kept and the top 5 bits received have no effect. The array location is the address modulo the array depth.
- R4: In a read or write burst the address advances by one after each byte and wraps from 0x7FFFF to 0.
- R5: A data write or status write changes nothing unless the write-enable latch is set. The latch is visible as status bit 1. Command 0x06 sets it and command 0x04 clears it.
- R6: The write-enable latch clears when select rises at the end of a data-write or status-write command.
- R7: The read-status command returns {stored bits 7:2, latch, 0}, and repeats that byte for as long as clocks continue. The write-status command updates stored bits 7:2 from its data byte.
- R8: After an unrecognised command byte, the output enable stays low and all further input is ignored until select next falls.
- R9: The output bit changes only after a falling clock edge. The output enable is high only during read-data or read-status commands while select is low.
- R10: After reset the output enable is low, the status reads 0x00 and every array byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the bus master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the serial data pin |

## Verification
A wrong address counter shows up at the pins within one byte time of a read burst. The bytes come back out of order or from the wrong location, and the bench sees this because it computes each location's contents arithmetically. A stuck or misdecoded command state shows up as the output enable rising during a rejected command, or as a write landing while the latch is clear. A readback in the very next select frame exposes either fault. A latch that fails to clear or set is visible in the next status read, so every latch transition is followed by one.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] OP_WEN_SET = 8'h06;
    localparam logic [7:0] OP_WEN_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_DATA_RD = 8'h03;
    localparam logic [7:0] OP_DATA_WR = 8'h02;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADR,
        ST_RDAT,
        ST_WDAT,
        ST_RSTAT,
        ST_WSTAT,
        ST_DONE,
        ST_LOCK
    } slv_state_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          N       = 3,
    parameter logic [31:0] RST_VAL = 32'h1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] pin_s,
    output logic [N-1:0] pin_rise,
    output logic [N-1:0] pin_fall
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [2:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[1:0], pin_in[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= {3{RST_VAL[g]}};
            else        sh_q <= sh_d;
        end

        assign pin_s[g]    = sh_q[1];
        assign pin_rise[g] = sh_q[1] & ~sh_q[2];
        assign pin_fall[g] = ~sh_q[1] & sh_q[2];
    end

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/spi_fram_slave.sv
module spi_fram_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int MEM_DEPTH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);

    localparam int IDX_W = $clog2(MEM_DEPTH);

    typedef struct packed {
        slv_state_e        state;
        logic [2:0]        bit_cnt;
        logic [6:0]        rx_sh;
        logic [1:0]        adr_cnt;
        logic              is_rd;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        tx_sh;
        logic              tx_load;
        logic              miso;
        logic              oe;
        logic              wel;
        logic [5:0]        stat;
        logic              clr_pend;
    } slv_regs_t;

    slv_regs_t d, q;

    logic [2:0] pin_s, pin_rise, pin_fall;
    logic       cs_hi, sck_rise, sck_fall, mosi_s;

    spi_pin_sync #(.N(3), .RST_VAL(32'h1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   ({spi_mosi, spi_sck, spi_cs_n}),
        .pin_s    (pin_s),
        .pin_rise (pin_rise),
        .pin_fall (pin_fall)
    );

    assign cs_hi    = pin_s[0];
    assign sck_rise = pin_rise[1];
    assign sck_fall = pin_fall[1];
    assign mosi_s   = pin_s[2];

    logic             mem_we;
    logic [IDX_W-1:0] mem_waddr;
    logic [7:0]       mem_wdata, mem_rdata;

    spi_mem_array #(.DEPTH(MEM_DEPTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (q.addr[IDX_W-1:0]),
        .rdata (mem_rdata)
    );

    logic                rx_take, byte_done;
    logic [7:0]          rx_byte, stat_byte;
    logic [ADDR_W+7:0]   adr_cat;

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_waddr = q.addr[IDX_W-1:0];
        mem_wdata = '0;
        stat_byte = {q.stat, q.wel, 1'b0};
        rx_take   = sck_rise && (q.state != ST_LOCK) && (q.state != ST_DONE);
        byte_done = rx_take && (q.bit_cnt == 3'd7);
        rx_byte   = {q.rx_sh, mosi_s};
        adr_cat   = {q.addr, rx_byte};

        if (cs_hi) begin
            d.state   = ST_CMD;
            d.bit_cnt = '0;
            d.oe      = 1'b0;
            d.tx_load = 1'b0;
            if (q.clr_pend) begin
                d.wel      = 1'b0;
                d.clr_pend = 1'b0;
            end
        end else begin
            if (rx_take) begin
                d.bit_cnt = q.bit_cnt + 3'd1;
                d.rx_sh   = rx_byte[6:0];
            end
            unique case (q.state)
                ST_CMD: if (byte_done) begin
                    unique case (rx_byte)
                        OP_WEN_SET: begin d.wel = 1'b1; d.state = ST_DONE; end
                        OP_WEN_CLR: begin d.wel = 1'b0; d.state = ST_DONE; end
                        OP_STAT_RD: begin
                            d.state = ST_RSTAT;
                            d.tx_sh = stat_byte;
                            d.oe    = 1'b1;
                        end
                        OP_STAT_WR: begin d.state = ST_WSTAT; d.clr_pend = 1'b1; end
                        OP_DATA_RD: begin d.state = ST_ADR; d.adr_cnt = '0; d.is_rd = 1'b1; end
                        OP_DATA_WR: begin
                            d.state    = ST_ADR;
                            d.adr_cnt  = '0;
                            d.is_rd    = 1'b0;
                            d.clr_pend = 1'b1;
                        end
                        default: d.state = ST_LOCK;
                    endcase
                end
                ST_ADR: if (byte_done) begin
                    d.addr    = adr_cat[ADDR_W-1:0];
                    d.adr_cnt = q.adr_cnt + 2'd1;
                    if (q.adr_cnt == 2'd2) begin
                        d.state   = q.is_rd ? ST_RDAT : ST_WDAT;
                        d.oe      = q.is_rd;
                        d.tx_load = q.is_rd;
                    end
                end
                ST_RDAT: begin
                    if (q.tx_load) begin
                        d.tx_sh   = mem_rdata;
                        d.tx_load = 1'b0;
                    end
                    if (sck_fall) begin
                        d.miso  = q.tx_sh[7];
                        d.tx_sh = {q.tx_sh[6:0], 1'b0};
                        if (q.bit_cnt == 3'd7) begin
                            d.addr    = q.addr + 1'b1;
                            d.tx_load = 1'b1;
                        end
                    end
                end
                ST_RSTAT: if (sck_fall) begin
                    d.miso  = q.tx_sh[7];
                    d.tx_sh = (q.bit_cnt == 3'd7) ? stat_byte : {q.tx_sh[6:0], 1'b0};
                end
                ST_WDAT: if (byte_done) begin
                    mem_we    = q.wel;
                    mem_wdata = rx_byte;
                    d.addr    = q.addr + 1'b1;
                end
                ST_WSTAT: if (byte_done) begin
                    if (q.wel) d.stat = rx_byte[7:2];
                    d.state = ST_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_CMD;
        end else begin
            q <= d;
        end
    end

    assign spi_miso    = q.miso;
    assign spi_miso_oe = q.oe;

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_LOCK && !cs_hi) |=> (q.state == ST_LOCK)); // R8
    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_LOCK) |-> !spi_miso_oe); // R8
    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(spi_miso)); // R9
    AST_OE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !spi_miso_oe); // R9
    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> (q.state == ST_RDAT || q.state == ST_RSTAT)); // R9
    AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi && q.clr_pend) |=> !q.wel); // R6
    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (q.wel && q.state == ST_WDAT)); // R5
    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WDAT && byte_done && !cs_hi && q.addr == {ADDR_W{1'b1}})
        |=> (q.addr == '0)); // R4

endmodule

// File: tb/sim_spi_fram_slave.sv
module sim_spi_fram_slave;

    localparam int H     = 10;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe;
    logic mode3 = 1'b0;
    int   total = 0, bad = 0;
    logic oe_seen = 1'b0, mon_en = 1'b0, edge_bad = 1'b0;
    logic [7:0] rx;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    spi_fram_slave #(.ADDR_W(19), .MEM_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    always @(negedge clk) if (mon_en && miso_oe) oe_seen = 1'b1;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        @(negedge clk);
        sck  = mode3;
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic cs_end();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rxb);
        for (int i = 7; i >= 0; i--) begin
            sck  = 1'b0;
            mosi = tx[i];
            wait_clk(H);
            rxb[i] = miso;
            sck = 1'b1;
            wait_clk(H - 1);
            if (miso_oe && miso !== rxb[i]) edge_bad = 1'b1;
            wait_clk(1);
        end
    endtask

    task automatic simple_cmd(input logic [7:0] op);
        logic [7:0] r;
        cs_begin(); xfer(op, r); cs_end();
    endtask

    task automatic read_stat(output logic [7:0] s);
        logic [7:0] r;
        cs_begin(); xfer(8'h05, r); xfer(8'h00, s); cs_end();
    endtask

    task automatic send_addr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] r;
        xfer(op, r); xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
    endtask

    task automatic read1(input logic [23:0] a, output logic [7:0] v);
        cs_begin(); send_addr(8'h03, a); xfer(8'h00, v); cs_end();
    endtask

    task automatic write1(input logic [23:0] a, input logic [7:0] v);
        logic [7:0] r;
        cs_begin(); send_addr(8'h02, a); xfer(v, r); cs_end();
    endtask

    initial begin
        logic [7:0] s, r;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R10: reset state
        check("R10 oe after reset", 32'(miso_oe), 32'h0);
        read_stat(s);
        check("R10 status after reset", 32'(s), 32'h00);
        read1(24'h000010, r);
        check("R10 array after reset", 32'(r), 32'h00);

        // R5: write without latch ignored
        write1(24'h000003, 8'h5A);
        read1(24'h000003, r);
        check("R5 write without latch", 32'(r), 32'h00);
        simple_cmd(8'h06);
        read_stat(s);
        check("R5 latch set by 0x06", 32'(s), 32'h02);
        simple_cmd(8'h04);
        read_stat(s);
        check("R5 latch cleared by 0x04", 32'(s), 32'h00);

        // R1 R4: burst write all locations, clock idles low
        simple_cmd(8'h06);
        cs_begin();
        send_addr(8'h02, 24'h000000);
        for (int i = 0; i < DEPTH; i++) xfer(pat(i), r);
        cs_end();
        read_stat(s);
        check("R6 latch cleared after write", 32'(s), 32'h00);

        // R1 R4 R9: burst read, clock idles high, past the array end
        mode3 = 1'b1;
        edge_bad = 1'b0;
        cs_begin();
        send_addr(8'h03, 24'h000000);
        for (int i = 0; i < DEPTH + 2; i++) begin
            xfer(8'h00, r);
            check("R1 R4 burst read clock-high idle", 32'(r), 32'(pat(i % DEPTH)));
        end
        check("R9 oe high during read", 32'(miso_oe), 32'h1);
        cs_end();
        check("R9 oe low after deselect", 32'(miso_oe), 32'h0);
        check("R9 output held while clock high", 32'(edge_bad), 32'h0);

        // R4: wrap at top of 19-bit space, clock idles low
        mode3 = 1'b0;
        cs_begin();
        send_addr(8'h03, 24'h07FFFE);
        for (int i = 0; i < 4; i++) begin
            xfer(8'h00, r);
            check("R4 wrap from top address", 32'(r), 32'(pat((62 + i) % DEPTH)));
        end
        cs_end();

        // R3: top address bits ignored
        mode3 = 1'b1;
        simple_cmd(8'h06);
        write1(24'hF80005, 8'hA5);
        read1(24'h000005, r);
        check("R3 upper five bits ignored", 32'(r), 32'hA5);
        read1(24'h080005, r);
        check("R3 bit 19 ignored", 32'(r), 32'hA5);
        read1(24'h000045, r);
        check("R3 aliasing modulo depth", 32'(r), 32'hA5);

        // R8 R2: rejected commands, latch set beforehand
        mode3 = 1'b0;
        simple_cmd(8'h06);
        for (int k = 0; k < 256; k += 9) begin
            if (k == 8'h06 || k == 8'h04 || k == 8'h05 ||
                k == 8'h01 || k == 8'h03 || k == 8'h02) continue;
            oe_seen = 1'b0;
            mon_en  = 1'b1;
            cs_begin();
            xfer(8'(k), r);
            xfer(8'h02, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h05, r); xfer(8'h00, r);
            cs_end();
            mon_en = 1'b0;
            check("R8 output enable stays low", 32'(oe_seen), 32'h0);
        end
        read1(24'h000005, r);
        check("R8 data after reject ignored", 32'(r), 32'hA5);
        read_stat(s);
        check("R8 R2 latch kept, next frame decoded", 32'(s), 32'h02);

        // R7: status write and repeated read
        cs_begin(); xfer(8'h01, r); xfer(8'hFF, r); cs_end();
        read_stat(s);
        check("R7 status write keeps bit0 zero, R6 latch cleared", 32'(s), 32'hFC);
        cs_begin(); xfer(8'h01, r); xfer(8'h00, r); cs_end();
        read_stat(s);
        check("R7 R5 status write without latch", 32'(s), 32'hFC);
        mode3 = 1'b1;
        cs_begin();
        xfer(8'h05, r);
        for (int i = 0; i < 3; i++) begin
            xfer(8'h00, r);
            check("R7 status repeats", 32'(r), 32'hFC);
        end
        cs_end();
        simple_cmd(8'h06);
        cs_begin(); xfer(8'h01, r); xfer(8'h24, r); cs_end();
        read_stat(s);
        check("R7 status write with latch", 32'(s), 32'h24);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule